// File: doc/BRIEF.md
# Capture Byte Read Sequencer

This block lets a host collect audio capture samples one byte at a time through a single 8-bit data port. Each sample-valid strobe captures a left and a right sample word. After that, every host read strobe moves a byte pointer on to the next byte of the sample. The sample can be 8-bit or 16-bit, and mono or stereo. When every byte has been read, the pointer parks on the last byte. It leaves that byte only when the next sample arrives.

The block drives four live status bits. One shows whether the next byte is the upper or lower byte. One shows whether the next channel is left or right. One shows whether the held data is fresh. One records whether the most recent sample arrived before the previous one was fully read. While an initialization flag is high, the data port returns a fixed idle pattern and host reads have no effect.

Top module: `pio_capture_reader`

## Requirements
- R1: After synchronous active-high reset, and until the first sample strobe, `rd_data` is 8'h80, `stat_fresh` is 0 and `stat_overrun` is 0.
- R2: `rd_data` shows the byte under the pointer, and each host read moves the pointer to the next byte. With `wide_mode`=1 and `stereo_mode`=1 the order is left[7:0], left[15:8], right[7:0], right[15:8]. With `wide_mode`=1 and `stereo_mode`=0 it is left[7:0], left[15:8]. In 8-bit mode (`wide_mode`=0) each channel supplies bits [15:8] of its word: stereo gives left then right, and mono gives left only.
- R3: Once the pointer reaches the final byte, further reads leave it there and keep returning that most significant byte.
- R4: A sample strobe captures both words and puts the pointer back on the first byte. In the next cycle `stat_fresh` is 1.
- R5: `stat_upper` is 1 when the next byte is an upper byte and 0 when it is a lower byte. It is always 1 in 8-bit mode.
- R6: `stat_left` is 1 when the next byte belongs to the left channel and 0 when it belongs to the right channel. It is always 1 in mono.
- R7: `stat_fresh` drops to 0 after the final byte of a sample is read.
- R8: Every sample strobe updates `stat_overrun`. It becomes 1 if `stat_fresh` was still 1, meaning unread bytes remained, and 0 otherwise.
- R9: While `init_active` is 1, `rd_data` is 8'h80 and host reads do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New ADC sample strobe |
| smp_left | input | 16 | Left (or mono) sample word |
| smp_right | input | 16 | Right sample word |
| rd_strobe | input | 1 | Host read of the data port |
| wide_mode | input | 1 | 1 = 16-bit samples, 0 = 8-bit |
| stereo_mode | input | 1 | 1 = stereo, 0 = mono |
| init_active | input | 1 | Initialization in progress |
| rd_data | output | 8 | Data port byte |
| stat_upper | output | 1 | Next byte is upper |
| stat_left | output | 1 | Next channel is left |
| stat_fresh | output | 1 | Held data is fresh |
| stat_overrun | output | 1 | Last sample arrived unserviced |

## Verification
The bench builds the block with its default 8-bit byte width. That makes the sample 16 bits wide and caps the pointer at four positions. With so few positions, all four width and channel combinations can be swept exhaustively. In each combination, every byte position is visited, the pointer is held parked across repeated reads, and samples are issued both with and without a pending unread sample. The expected bytes are worked out arithmetically from the words the bench drives. This brings every pointer state, every status encoding and both overrun outcomes within reach, together with the initialization override.

// File: rtl/pio_cap_pkg.sv
package pio_cap_pkg;

    typedef struct packed {
        logic [1:0] ptr;
        logic       fresh;
        logic       overrun;
        logic       loaded;
    } seq_state_t;

    function automatic logic [1:0] last_index(input logic wide, input logic stereo);
        return {wide & stereo, wide | stereo};
    endfunction

endpackage

// File: rtl/capture_sample_hold.sv
module capture_sample_hold #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o
);
    logic [WORD_W-1:0] left_d, left_q, right_d, right_q;

    always_comb begin
        left_d  = left_q;
        right_d = right_q;
        if (load_i) begin
            left_d  = left_i;
            right_d = right_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            right_q <= '0;
        end else begin
            left_q  <= left_d;
            right_q <= right_d;
        end
    end

    assign left_o  = left_q;
    assign right_o = right_q;
endmodule

// File: rtl/capture_byte_sel.sv
module capture_byte_sel #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [1:0]        ptr_i,
    input  logic              wide_i,
    input  logic              stereo_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              upper_o,
    output logic              left_o
);
    logic [BYTE_W-1:0] lane [2][2];
    logic              chan_right;
    logic              hi_sel;

    for (genvar b = 0; b < 2; b++) begin : g_lane
        assign lane[0][b] = left_i[b*BYTE_W +: BYTE_W];
        assign lane[1][b] = right_i[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        chan_right = stereo_i & (wide_i ? ptr_i[1] : ptr_i[0]);
        hi_sel     = wide_i ? ptr_i[0] : 1'b1;
        byte_o     = lane[chan_right][hi_sel];
        upper_o    = hi_sel;
        left_o     = ~chan_right;
    end
endmodule

// File: rtl/capture_seq_ctrl.sv
module capture_seq_ctrl
    import pio_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp_valid_i,
    input  logic       rd_i,
    input  logic       init_i,
    input  logic       wide_i,
    input  logic       stereo_i,
    output seq_state_t state_o
);
    seq_state_t state_d, state_q;
    logic [1:0] last;
    logic       rd_ok;
    logic       at_end;

    always_comb begin
        last    = last_index(wide_i, stereo_i);
        rd_ok   = rd_i & ~init_i;
        at_end  = (state_q.ptr >= last);
        state_d = state_q;
        if (smp_valid_i) begin
            state_d.ptr     = '0;
            state_d.fresh   = 1'b1;
            state_d.loaded  = 1'b1;
            state_d.overrun = state_q.fresh & ~(rd_ok & at_end);
        end else if (rd_ok) begin
            if (at_end) begin
                state_d.fresh = 1'b0;
            end else begin
                state_d.ptr = state_q.ptr + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    assert_first_after_sample_R4: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i |=> (state_q.ptr == 2'd0 && state_q.fresh));

    assert_init_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (init_i && rd_i && !smp_valid_i) |=> $stable(state_q.ptr));

    assert_parked_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && !smp_valid_i && at_end) |=> $stable(state_q.ptr));

    assert_fresh_drop_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(state_q.fresh) |-> $past(rd_i));

    assert_overrun_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q.overrun) |-> $past(smp_valid_i));
endmodule

// File: rtl/pio_capture_reader.sv
module pio_capture_reader
    import pio_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [15:0] smp_left,
    input  logic [15:0] smp_right,
    input  logic        rd_strobe,
    input  logic        wide_mode,
    input  logic        stereo_mode,
    input  logic        init_active,
    output logic [7:0]  rd_data,
    output logic        stat_upper,
    output logic        stat_left,
    output logic        stat_fresh,
    output logic        stat_overrun
);
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h80;

    seq_state_t        state;
    logic [15:0]       held_left, held_right;
    logic [BYTE_W-1:0] sel_byte;

    capture_sample_hold #(.BYTE_W(BYTE_W)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (smp_valid),
        .left_i  (smp_left),
        .right_i (smp_right),
        .left_o  (held_left),
        .right_o (held_right)
    );

    capture_seq_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .smp_valid_i (smp_valid),
        .rd_i        (rd_strobe),
        .init_i      (init_active),
        .wide_i      (wide_mode),
        .stereo_i    (stereo_mode),
        .state_o     (state)
    );

    capture_byte_sel #(.BYTE_W(BYTE_W)) sel_i (
        .ptr_i    (state.ptr),
        .wide_i   (wide_mode),
        .stereo_i (stereo_mode),
        .left_i   (held_left),
        .right_i  (held_right),
        .byte_o   (sel_byte),
        .upper_o  (stat_upper),
        .left_o   (stat_left)
    );

    assign rd_data      = (init_active || !state.loaded) ? IDLE_BYTE : sel_byte;
    assign stat_fresh   = state.fresh;
    assign stat_overrun = state.overrun;

    assert_mono_left_R6: assert property (@(posedge clk) disable iff (rst)
        !stereo_mode |-> stat_left);

    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> stat_upper);
endmodule

// File: tb/pio_capture_reader_tb_top.sv
module pio_capture_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid, rd_strobe, wide_mode, stereo_mode, init_active;
    logic [15:0] smp_left, smp_right;
    logic [7:0]  rd_data;
    logic        stat_upper, stat_left, stat_fresh, stat_overrun;
    int          checks = 0;
    int          failures = 0;

    always #2 clk = ~clk;

    pio_capture_reader dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .rd_strobe(rd_strobe), .wide_mode(wide_mode),
        .stereo_mode(stereo_mode), .init_active(init_active), .rd_data(rd_data),
        .stat_upper(stat_upper), .stat_left(stat_left), .stat_fresh(stat_fresh),
        .stat_overrun(stat_overrun)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic sample(input logic [15:0] l, input logic [15:0] r);
        smp_left = l; smp_right = r; smp_valid = 1'b1;
        tick();
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        tick();
    endtask

    function automatic int nbytes(input logic w, input logic s);
        return (w ? 2 : 1) * (s ? 2 : 1);
    endfunction

    function automatic logic exp_right(input logic w, input logic s, input int idx);
        return s && ((w ? idx / 2 : idx) == 1);
    endfunction

    function automatic logic exp_hi(input logic w, input int idx);
        return !w || (idx % 2 == 1);
    endfunction

    function automatic logic [7:0] exp_byte(input logic w, input logic s, input int idx,
                                            input logic [15:0] l, input logic [15:0] r);
        logic [15:0] word;
        word = exp_right(w, s, idx) ? r : l;
        return exp_hi(w, idx) ? word[15:8] : word[7:0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] l, r;
        rst = 1'b1; smp_valid = 0; rd_strobe = 0; init_active = 0;
        wide_mode = 1; stereo_mode = 1; smp_left = '0; smp_right = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle data", rd_data, 8'h80);
        check("R1 fresh", {7'b0, stat_fresh}, 8'h00);
        check("R1 overrun", {7'b0, stat_overrun}, 8'h00);
        host_read();
        check("R1 idle after read", rd_data, 8'h80);

        for (int m = 0; m < 4; m++) begin
            wide_mode = m[1]; stereo_mode = m[0];
            for (int t = 0; t < 4; t++) begin
                int n;
                n = nbytes(wide_mode, stereo_mode);
                l = 16'h1234 + 16'(t) * 16'h1111 + 16'(m) * 16'h0203;
                r = 16'hA5C3 - 16'(t) * 16'h0F0F + 16'(m) * 16'h0101;
                sample(l, r);
                check("R4 fresh after sample", {7'b0, stat_fresh}, 8'h01);
                check("R8 serviced sample", {7'b0, stat_overrun}, 8'h00);
                if (t % 2 == 1) begin
                    if (n > 1) host_read();
                    l = ~l; r = r ^ 16'h3C3C;
                    sample(l, r);
                    check("R8 overrun set", {7'b0, stat_overrun}, 8'h01);
                end
                for (int i = 0; i < n; i++) begin
                    check("R2 byte order", rd_data, exp_byte(wide_mode, stereo_mode, i, l, r));
                    check("R5 upper bit", {7'b0, stat_upper}, {7'b0, exp_hi(wide_mode, i)});
                    check("R6 left bit", {7'b0, stat_left},
                          {7'b0, !exp_right(wide_mode, stereo_mode, i)});
                    check("R4 fresh while reading", {7'b0, stat_fresh}, 8'h01);
                    host_read();
                end
                check("R7 fresh cleared", {7'b0, stat_fresh}, 8'h00);
                for (int k = 0; k < 2; k++) begin
                    check("R3 parked byte", rd_data, exp_byte(wide_mode, stereo_mode, n - 1, l, r));
                    check("R3 parked channel", {7'b0, stat_left},
                          {7'b0, !exp_right(wide_mode, stereo_mode, n - 1)});
                    host_read();
                end
            end
        end

        wide_mode = 1; stereo_mode = 1;
        sample(16'hBEEF, 16'hCAFE);
        init_active = 1'b1;
        @(negedge clk);
        check("R9 init data", rd_data, 8'h80);
        host_read();
        host_read();
        init_active = 1'b0;
        @(negedge clk);
        check("R9 pointer held", rd_data, 8'hEF);
        check("R9 fresh held", {7'b0, stat_fresh}, 8'h01);
        check("R5 first byte lower", {7'b0, stat_upper}, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule